// File: doc/BRIEF.md
# Branch Target Buffer

This block sits next to the fetch stage and remembers where taken branches went. Every cycle the fetch PC is compared against all stored branch addresses at once. When an entry matches and its two-bit state says "taken", the stored destination is offered as the next fetch address. Otherwise fetch simply advances by one instruction.

When a branch resolves later in the pipeline, the block is told the branch address, the real direction, the real destination and whether fetch guessed wrong. It then does one of the following:

- enters a new taken branch,
- strengthens, weakens or retargets an existing entry,
- drops an entry whose branch fell through against its prediction.

On a wrong guess it also issues a one-cycle kill pulse together with the address fetch must restart from. A correct guess produces no pulse, so fetch carries on without a stall.

Top module: `branch_target_buffer`

## Requirements
- R1: After reset every entry is empty: no lookup hits, `fetch_next_pc` is `fetch_pc` + 4 and `flush` is low.
- R2: A lookup that matches an entry whose state is 2 or 3 drives `fetch_hit`=1, `fetch_taken`=1 and `fetch_next_pc` equal to the stored destination.
- R3: A lookup that misses, or that matches an entry whose state is 0 or 1, drives `fetch_taken`=0 and `fetch_next_pc` = `fetch_pc` + 4. A matching entry still drives `fetch_hit`=1.
- R4: A resolved taken branch whose address is not stored is written into the buffer with state 2 (weakly taken), so its next lookup predicts the resolved destination.
- R5: A resolved not-taken branch whose address is not stored changes nothing in the buffer.
- R6: A resolved taken branch that is stored raises its state by one, saturating at 3, and replaces its destination with the resolved destination.
- R7: A stored branch that resolves not taken with the mispredict flag set is removed, so its next lookup misses.
- R8: A stored branch that resolves not taken without the mispredict flag lowers its state by one, saturating at 0.
- R9: A resolution with the mispredict flag makes `flush` high for exactly the following cycle. In that cycle `redirect_pc` is the resolved destination if the branch was taken, and the branch address + 4 if it was not.
- R10: A new entry goes to the lowest-numbered free slot. When no slot is free, it replaces slots in rotating order starting at slot 0, and the rotation advances only on such replacements.
- R11: A lookup and a resolution of the same address in one cycle give the lookup the contents held before that resolution.
- R12: A resolution without the mispredict flag leaves `flush` low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_pc | input | PC_W | Address being fetched this cycle |
| fetch_hit | output | 1 | Fetch address matches a stored entry |
| fetch_taken | output | 1 | Matching entry predicts taken |
| fetch_next_pc | output | PC_W | Predicted next fetch address |
| res_valid | input | 1 | A branch resolution is presented |
| res_pc | input | PC_W | Address of the resolved branch |
| res_taken | input | 1 | Actual direction of the branch |
| res_target | input | PC_W | Actual destination of the branch |
| res_mispredict | input | 1 | Fetch followed the wrong path for this branch |
| flush | output | 1 | One-cycle kill of wrongly fetched instructions |
| redirect_pc | output | PC_W | Restart address, valid while `flush` is high |

## Verification
Some properties are checked by assertions on every cycle:
- a mispredict is always followed by exactly one flush, and a taken correction carries the resolved destination;
- no flush appears without a mispredict;
- a taken prediction always comes with a hit, and a non-taken one always yields the sequential address;
- at most one entry matches a fetch address;
- a not-taken miss leaves the occupancy untouched, and a removal drops exactly one entry.

Other behaviour shows only across a scenario and is left to the bench:
- the saturating walk of the state through its four values;
- retargeting of an entry;
- the same-cycle old-contents lookup;
- the order in which slots are filled and then replaced.

// File: rtl/branch_target_buffer.sv
module branch_target_buffer #(
  parameter int ENTRIES     = 8,
  parameter int PC_W        = 32,
  parameter int INSTR_BYTES = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] fetch_pc,
  output logic            fetch_hit,
  output logic            fetch_taken,
  output logic [PC_W-1:0] fetch_next_pc,
  input  logic            res_valid,
  input  logic [PC_W-1:0] res_pc,
  input  logic            res_taken,
  input  logic [PC_W-1:0] res_target,
  input  logic            res_mispredict,
  output logic            flush,
  output logic [PC_W-1:0] redirect_pc
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [PC_W-1:0] STEP = PC_W'(INSTR_BYTES);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] vld;
  logic [PC_W-1:0]    tag_q [ENTRIES];
  logic [PC_W-1:0]    tgt_q [ENTRIES];
  logic [1:0]         ctr_q [ENTRIES];
  logic [IDX_W-1:0]   rr_q;

  logic [ENTRIES-1:0] f_match, r_match;
  logic [IDX_W-1:0]   f_idx, r_idx, free_idx, alloc_idx;
  logic               r_hit, any_free;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign f_match[g] = vld[g] && (tag_q[g] == fetch_pc);
    assign r_match[g] = vld[g] && (tag_q[g] == res_pc);
  end

  always_comb begin
    f_idx    = '0;
    r_idx    = '0;
    free_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (f_match[i]) f_idx = IDX_W'(i);
      if (r_match[i]) r_idx = IDX_W'(i);
    end
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!vld[i]) free_idx = IDX_W'(i);
  end

  assign r_hit     = |r_match;
  assign any_free  = ~&vld;
  assign alloc_idx = any_free ? free_idx : rr_q;

  assign fetch_hit     = |f_match;
  assign fetch_taken   = fetch_hit && ctr_q[f_idx][1];
  assign fetch_next_pc = fetch_taken ? tgt_q[f_idx] : fetch_pc + STEP;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld         <= '0;
      rr_q        <= '0;
      flush       <= 1'b0;
      redirect_pc <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        tag_q[i] <= '0;
        tgt_q[i] <= '0;
        ctr_q[i] <= 2'b00;
      end
    end else begin
      flush <= res_valid && res_mispredict;
      if (res_valid && res_mispredict)
        redirect_pc <= res_taken ? res_target : res_pc + STEP;
      if (res_valid) begin
        if (r_hit) begin
          if (res_taken) begin
            tgt_q[r_idx] <= res_target;
            if (ctr_q[r_idx] != 2'b11) ctr_q[r_idx] <= ctr_q[r_idx] + 2'b01;
          end else if (res_mispredict) begin
            vld[r_idx] <= 1'b0;
          end else if (ctr_q[r_idx] != 2'b00) begin
            ctr_q[r_idx] <= ctr_q[r_idx] - 2'b01;
          end
        end else if (res_taken) begin
          vld[alloc_idx]   <= 1'b1;
          tag_q[alloc_idx] <= res_pc;
          tgt_q[alloc_idx] <= res_target;
          ctr_q[alloc_idx] <= 2'b10;
          if (!any_free) rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
        end
      end
    end
  end

  a_r9_flush_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_mispredict) |=> flush);

  a_r12_no_spurious_flush: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_valid && res_mispredict) |=> !flush);

  a_r9_redirect_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_mispredict && res_taken) |=> (redirect_pc == $past(res_target)));

  a_r2_taken_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_taken |-> fetch_hit);

  a_r3_sequential: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_taken |-> (fetch_next_pc == fetch_pc + STEP));

  a_r10_unique_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(f_match));

  a_r5_no_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_taken && !r_hit) |=> $stable(vld));

  a_r7_delete: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && r_hit && !res_taken && res_mispredict)
      |=> ($countones(vld) == $countones($past(vld)) - 1));

endmodule

// File: tb/branch_target_buffer_tb.sv
module branch_target_buffer_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic        fetch_hit, fetch_taken;
  logic [31:0] fetch_next_pc;
  logic        res_valid = 1'b0;
  logic [31:0] res_pc = '0;
  logic        res_taken = 1'b0;
  logic [31:0] res_target = '0;
  logic        res_mispredict = 1'b0;
  logic        flush;
  logic [31:0] redirect_pc;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  branch_target_buffer u_dut (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
    .fetch_hit(fetch_hit), .fetch_taken(fetch_taken), .fetch_next_pc(fetch_next_pc),
    .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken),
    .res_target(res_target), .res_mispredict(res_mispredict),
    .flush(flush), .redirect_pc(redirect_pc)
  );

  typedef struct packed {
    logic        rv;
    logic [31:0] rpc;
    logic        rt;
    logic [31:0] rtg;
    logic        rm;
    logic [31:0] fpc;
    logic        eh;
    logic        et;
    logic [31:0] en;
    logic        ef;
    logic [31:0] er;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 32'h0,   1'b0, 32'h0,   1'b0, 32'h100, 1'b0, 1'b0, 32'h104, 1'b0, 32'h0,   8'd3},  // R3 empty miss
    '{1'b1, 32'h100, 1'b1, 32'h400, 1'b1, 32'h100, 1'b0, 1'b0, 32'h104, 1'b1, 32'h400, 8'd11}, // R11 R4 R9
    '{1'b0, 32'h0,   1'b0, 32'h0,   1'b0, 32'h100, 1'b1, 1'b1, 32'h400, 1'b0, 32'h0,   8'd4},  // R4 R2
    '{1'b1, 32'h100, 1'b1, 32'h400, 1'b0, 32'h100, 1'b1, 1'b1, 32'h400, 1'b0, 32'h0,   8'd12}, // R12 R6 2->3
    '{1'b1, 32'h100, 1'b0, 32'h0,   1'b0, 32'h100, 1'b1, 1'b1, 32'h400, 1'b0, 32'h0,   8'd8},  // R8 3->2
    '{1'b1, 32'h100, 1'b0, 32'h0,   1'b0, 32'h100, 1'b1, 1'b1, 32'h400, 1'b0, 32'h0,   8'd8},  // R8 2->1
    '{1'b0, 32'h0,   1'b0, 32'h0,   1'b0, 32'h100, 1'b1, 1'b0, 32'h104, 1'b0, 32'h0,   8'd8},  // R8 R3 hit not taken
    '{1'b1, 32'h100, 1'b0, 32'h0,   1'b0, 32'h100, 1'b1, 1'b0, 32'h104, 1'b0, 32'h0,   8'd8},  // R8 1->0
    '{1'b1, 32'h100, 1'b0, 32'h0,   1'b0, 32'h100, 1'b1, 1'b0, 32'h104, 1'b0, 32'h0,   8'd8},  // R8 saturate at 0
    '{1'b1, 32'h100, 1'b1, 32'h480, 1'b1, 32'h100, 1'b1, 1'b0, 32'h104, 1'b1, 32'h480, 8'd6},  // R6 0->1 retarget
    '{1'b1, 32'h100, 1'b1, 32'h480, 1'b1, 32'h100, 1'b1, 1'b0, 32'h104, 1'b1, 32'h480, 8'd6},  // R6 1->2
    '{1'b0, 32'h0,   1'b0, 32'h0,   1'b0, 32'h100, 1'b1, 1'b1, 32'h480, 1'b0, 32'h0,   8'd6},  // R6 new target used
    '{1'b1, 32'h100, 1'b0, 32'h0,   1'b1, 32'h100, 1'b1, 1'b1, 32'h480, 1'b1, 32'h104, 8'd7},  // R7 R9 fall-through
    '{1'b0, 32'h0,   1'b0, 32'h0,   1'b0, 32'h100, 1'b0, 1'b0, 32'h104, 1'b0, 32'h0,   8'd7},  // R7 removed
    '{1'b1, 32'h300, 1'b0, 32'h0,   1'b0, 32'h300, 1'b0, 1'b0, 32'h304, 1'b0, 32'h0,   8'd5},  // R5
    '{1'b0, 32'h0,   1'b0, 32'h0,   1'b0, 32'h300, 1'b0, 1'b0, 32'h304, 1'b0, 32'h0,   8'd5},  // R5 not entered
    '{1'b1, 32'h500, 1'b0, 32'h0,   1'b1, 32'h500, 1'b0, 1'b0, 32'h504, 1'b1, 32'h504, 8'd9},  // R9 miss fall-through
    '{1'b0, 32'h0,   1'b0, 32'h0,   1'b0, 32'h500, 1'b0, 1'b0, 32'h504, 1'b0, 32'h0,   8'd5}   // R5 still absent
  };

  task automatic chk(input int req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic cyc(input vec_t v);
    @(negedge clk);
    res_valid = v.rv; res_pc = v.rpc; res_taken = v.rt;
    res_target = v.rtg; res_mispredict = v.rm; fetch_pc = v.fpc;
    #1;
    chk(v.req, "hit", 32'(fetch_hit), 32'(v.eh));
    chk(v.req, "taken", 32'(fetch_taken), 32'(v.et));
    chk(v.req, "next_pc", fetch_next_pc, v.en);
    @(posedge clk);
    #1;
    chk(v.req, "flush", 32'(flush), 32'(v.ef));
    if (v.ef) chk(v.req, "redirect", redirect_pc, v.er);
  endtask

  task automatic resolve(input logic [31:0] pc, input logic tk, input logic [31:0] tg, input logic mp);
    @(negedge clk);
    res_valid = 1'b1; res_pc = pc; res_taken = tk; res_target = tg; res_mispredict = mp;
    @(posedge clk);
    #1;
  endtask

  task automatic look(input int req, input logic [31:0] pc, input logic eh, input logic [31:0] en);
    @(negedge clk);
    res_valid = 1'b0; fetch_pc = pc;
    #1;
    chk(req, "hit", 32'(fetch_hit), 32'(eh));
    chk(req, "next_pc", fetch_next_pc, en);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    fetch_pc = 32'h100;
    #1;
    chk(1, "flush after reset", 32'(flush), 32'd0);   // R1
    chk(1, "hit after reset", 32'(fetch_hit), 32'd0); // R1
    chk(1, "next_pc after reset", fetch_next_pc, 32'h104);

    for (int k = 0; k < NV; k++) cyc(VEC[k]);

    // R10: fill all slots in order, then rotate replacement
    for (int i = 0; i < 8; i++) resolve(32'h1000 + 32'(16 * i), 1'b1, 32'h2000 + 32'(16 * i), 1'b1);
    look(10, 32'h1070, 1'b1, 32'h2070);
    look(10, 32'h1000, 1'b1, 32'h2000);
    resolve(32'h1800, 1'b1, 32'h2800, 1'b1);
    look(10, 32'h1000, 1'b0, 32'h1004);
    look(10, 32'h1800, 1'b1, 32'h2800);
    resolve(32'h1900, 1'b1, 32'h2900, 1'b1);
    look(10, 32'h1010, 1'b0, 32'h1014);
    look(10, 32'h1020, 1'b1, 32'h2020);
    resolve(32'h1040, 1'b0, 32'h0, 1'b1);      // R7 frees a slot
    resolve(32'h1a00, 1'b1, 32'h2a00, 1'b1);   // R10 fills the free slot
    look(10, 32'h1020, 1'b1, 32'h2020);
    resolve(32'h1b00, 1'b1, 32'h2b00, 1'b1);   // R10 rotation resumes at slot 2
    look(10, 32'h1020, 1'b0, 32'h1024);
    look(10, 32'h1030, 1'b1, 32'h2030);
    look(10, 32'h1a00, 1'b1, 32'h2a00);
    look(10, 32'h1b00, 1'b1, 32'h2b00);
    look(10, 32'h1800, 1'b1, 32'h2800);

    // R1: reset empties a full table
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    look(1, 32'h1800, 1'b0, 32'h1804);
    look(1, 32'h1030, 1'b0, 32'h1034);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule